// File: doc/BRIEF.md
# Shared-Memory Fetch/Execute Sequencer

This block lets a small processor core run from one memory that has a single address input and a single read-data output, with instructions and data in the same array. Because one port cannot serve an instruction access and a data access together, the block splits time into two alternating phases. In the fetch phase the memory address is the program counter, and the returned word is captured in an instruction register. In the execute phase the memory address is the data address, and the read word is steered to the core's data path. A data read and a single write take place in the execute phase.

The data address in the execute phase comes from one of two places. It is either a parameterised field of the latched instruction or an address register supplied by the core, chosen per instruction by a select input. The program counter is kept inside the block. It either steps or loads a jump target at the end of each execute phase. Instruction decode and the arithmetic unit stay in the core. The memory is assumed to read combinationally and to write on the clock edge while its write enable is high.

Top module: `memseq_top`

## Requirements
- R1: A synchronous, active-high `rst` puts the block in the fetch phase (`exec_phase` = 0), sets `pc` to the parameter `RESET_PC` and clears `instr` to zero. These values are visible in the cycle after the reset edge.
- R2: Outside reset, `exec_phase` inverts on every rising clock edge. The value 0 marks fetch and 1 marks execute, so each instruction takes exactly two cycles.
- R3: During fetch, `mem_addr` equals `pc`.
- R4: On the clock edge that ends a fetch cycle, `instr` loads the `mem_rdata` value present in that cycle. `instr` does not change on the edge that ends an execute cycle.
- R5: During execute, `mem_addr` equals `reg_daddr` when `daddr_sel` = 1. When `daddr_sel` = 0 it equals `instr[FIELD_LSB +: AW]`.
- R6: `mem_we` is 1 exactly when `exec_phase` = 1 and `wr_req` = 1. `mem_wdata` always equals `wr_data`.
- R7: During execute, `rd_data` equals `mem_rdata` and `rd_valid` = 1. During fetch, `rd_data` is zero and `rd_valid` = 0 (with `ZERO_IDLE` = 1).
- R8: On the edge that ends an execute cycle, `pc` becomes `jump_tgt` if `jump_req` = 1 and `pc + 1` modulo 2^AW otherwise. On the edge that ends a fetch cycle, `pc` keeps its value.
- R9: `wr_req` and `jump_req` have no effect during fetch. No memory write takes place, and `pc` is unchanged after the fetch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jump_req | input | 1 | Core requests a jump at the end of execute |
| jump_tgt | input | AW | Jump target address |
| daddr_sel | input | 1 | 1: data address from `reg_daddr`, 0: from the instruction field |
| reg_daddr | input | AW | Data address held in a core register |
| wr_req | input | 1 | Core requests a memory write this instruction |
| wr_data | input | DW | Word to be written |
| mem_rdata | input | DW | Read data from the shared memory |
| mem_addr | output | AW | Address to the shared memory |
| mem_we | output | 1 | Write enable to the shared memory |
| mem_wdata | output | DW | Write data to the shared memory |
| pc | output | AW | Program counter |
| instr | output | DW | Latched instruction word |
| exec_phase | output | 1 | 0 = fetch, 1 = execute |
| rd_data | output | DW | Data-path read word |
| rd_valid | output | 1 | `rd_data` carries a data read |

## Verification
The bench builds the block with AW = 8, DW = 16, FIELD_LSB = 3, RESET_PC = 8'hF0 and ZERO_IDLE = 1. The non-zero field offset makes a mis-sliced instruction address visible. A reset value near the top of the address space lets the counter wrap to zero within a few instructions. With only 256 words, random writes often land on words that are fetched later, so a misrouted write shows up in the instruction stream. Directed steps cover jumps and writes requested in fetch, an explicit wrap from 8'hFF, and a reset asserted during execute.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
   typedef enum logic {
      PH_FETCH = 1'b0,
      PH_EXEC  = 1'b1
   } phase_e;
endpackage

// File: rtl/memseq_phase.sv
module memseq_phase
   import memseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   output phase_e phase_o
);
   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst)
         phase_q <= PH_FETCH;
      else
         phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
   end

   assign phase_o = phase_q;

   // R2
   phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));
   // R2
   phase_back_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));
endmodule

// File: rtl/memseq_pc.sv
module memseq_pc #(
   parameter int          AW       = 8,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          exec_i,
   input  logic          jump_i,
   input  logic [AW-1:0] tgt_i,
   output logic [AW-1:0] pc_o
);
   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_next;

   always_comb begin
      pc_next = pc_q;
      if (exec_i)
         pc_next = jump_i ? tgt_i : pc_q + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= RESET_PC;
      else
         pc_q <= pc_next;
   end

   assign pc_o = pc_q;

   // R8
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      exec_i |=> (pc_q == ($past(jump_i) ? $past(tgt_i) : $past(pc_q) + AW'(1))));
   // R8 R9
   pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !exec_i |=> $stable(pc_q));
endmodule

// File: rtl/memseq_ir.sv
module memseq_ir #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [DW-1:0] d_i,
   output logic [DW-1:0] q_o
);
   logic [DW-1:0] ir_q;

   always_ff @(posedge clk) begin
      if (rst)
         ir_q <= '0;
      else if (load_i)
         ir_q <= d_i;
   end

   assign q_o = ir_q;

   // R4
   ir_load_chk: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (ir_q == $past(d_i)));
   // R4
   ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(ir_q));
endmodule

// File: rtl/memseq_route.sv
module memseq_route #(
   parameter int AW        = 8,
   parameter int DW        = 16,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic          exec_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] field_i,
   input  logic [AW-1:0] reg_i,
   input  logic          sel_reg_i,
   input  logic          wr_req_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [DW-1:0] rdata_i,
   output logic [AW-1:0] addr_o,
   output logic          we_o,
   output logic [DW-1:0] wdata_o,
   output logic [DW-1:0] dout_o,
   output logic          dvalid_o
);
   logic [AW-1:0] data_addr;

   // data address source, then the phase address mux
   assign data_addr = sel_reg_i ? reg_i : field_i;
   assign addr_o    = exec_i ? data_addr : pc_i;

   // writes only in execute
   assign we_o    = exec_i & wr_req_i;
   assign wdata_o = wr_data_i;

   // read-data demux toward the data path
   assign dvalid_o = exec_i;
   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign dout_o = exec_i ? rdata_i : '0;
      end else begin : g_pass
         assign dout_o = rdata_i;
      end
   endgenerate
endmodule

// File: rtl/memseq_top.sv
module memseq_top #(
   parameter int            AW        = 8,
   parameter int            DW        = 16,
   parameter int            FIELD_LSB = 0,
   parameter logic [AW-1:0] RESET_PC  = '0,
   parameter bit            ZERO_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          jump_req,
   input  logic [AW-1:0] jump_tgt,
   input  logic          daddr_sel,
   input  logic [AW-1:0] reg_daddr,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic [AW-1:0] pc,
   output logic [DW-1:0] instr,
   output logic          exec_phase,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   import memseq_pkg::*;

   localparam int FIELD_MSB = FIELD_LSB + AW - 1;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("memseq_top: AW must be at least 2");
      end
      if (FIELD_LSB < 0 || FIELD_MSB >= DW) begin : g_bad_field
         $error("memseq_top: address field does not fit in the instruction word");
      end
   endgenerate

   phase_e        phase;
   logic          in_exec;
   logic [AW-1:0] field_addr;

   memseq_phase u_phase (
      .clk     (clk),
      .rst     (rst),
      .phase_o (phase)
   );

   assign in_exec    = (phase == PH_EXEC);
   assign exec_phase = in_exec;

   memseq_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .exec_i (in_exec),
      .jump_i (jump_req),
      .tgt_i  (jump_tgt),
      .pc_o   (pc)
   );

   memseq_ir #(.DW(DW)) u_ir (
      .clk    (clk),
      .rst    (rst),
      .load_i (!in_exec),
      .d_i    (mem_rdata),
      .q_o    (instr)
   );

   assign field_addr = instr[FIELD_MSB:FIELD_LSB];

   memseq_route #(.AW(AW), .DW(DW), .ZERO_IDLE(ZERO_IDLE)) u_route (
      .exec_i    (in_exec),
      .pc_i      (pc),
      .field_i   (field_addr),
      .reg_i     (reg_daddr),
      .sel_reg_i (daddr_sel),
      .wr_req_i  (wr_req),
      .wr_data_i (wr_data),
      .rdata_i   (mem_rdata),
      .addr_o    (mem_addr),
      .we_o      (mem_we),
      .wdata_o   (mem_wdata),
      .dout_o    (rd_data),
      .dvalid_o  (rd_valid)
   );

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!exec_phase && pc == RESET_PC && instr == '0));
   // R3
   fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
      !exec_phase |-> (mem_addr == pc));
   // R5
   exec_reg_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_phase && daddr_sel) |-> (mem_addr == reg_daddr));
   // R6 R9
   write_gate_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (exec_phase && wr_req));
   // R7
   read_valid_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> exec_phase);
endmodule

// File: tb/sim_memseq_top.sv
module sim_memseq_top;
   localparam int            AW  = 8;
   localparam int            DW  = 16;
   localparam int            FL  = 3;
   localparam logic [AW-1:0] RPC = 8'hF0;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          jump_req = 1'b0;
   logic [AW-1:0] jump_tgt = '0;
   logic          daddr_sel = 1'b0;
   logic [AW-1:0] reg_daddr = '0;
   logic          wr_req = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata;
   logic [AW-1:0] pc;
   logic [DW-1:0] instr;
   logic          exec_phase;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   logic [DW-1:0] mem [256];
   assign mem_rdata = mem[mem_addr];

   always #2.5 clk = ~clk;

   memseq_top #(.AW(AW), .DW(DW), .FIELD_LSB(FL), .RESET_PC(RPC), .ZERO_IDLE(1'b1)) u0 (
      .clk(clk), .rst(rst), .jump_req(jump_req), .jump_tgt(jump_tgt),
      .daddr_sel(daddr_sel), .reg_daddr(reg_daddr), .wr_req(wr_req),
      .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .pc(pc), .instr(instr),
      .exec_phase(exec_phase), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   // reference model state
   bit            m_exec;
   logic [AW-1:0] m_pc;
   logic [DW-1:0] m_ir;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr(input bit ex, input bit sel, input logic [AW-1:0] rd);
      if (!ex) return m_pc;
      return sel ? rd : m_ir[FL +: AW];
   endfunction

   function automatic logic [AW-1:0] exp_next_pc(input bit ex, input bit jr, input logic [AW-1:0] jt);
      if (!ex) return m_pc;
      return jr ? jt : m_pc + 8'd1;
   endfunction

   task automatic model_reset();
      m_exec = 1'b0;
      m_pc   = RPC;
      m_ir   = '0;
   endtask

   // one clock: drive after negedge, check before posedge, update model at posedge
   task automatic step(input bit jr, input logic [AW-1:0] jt, input bit ds,
                       input logic [AW-1:0] ra, input bit wr, input logic [DW-1:0] wd);
      logic [AW-1:0] ea;
      logic          s_we;
      logic [AW-1:0] s_addr;
      logic [DW-1:0] s_wd;
      jump_req = jr; jump_tgt = jt; daddr_sel = ds; reg_daddr = ra;
      wr_req = wr; wr_data = wd;
      #1;
      ea = exp_addr(m_exec, ds, ra);
      chk("R2 phase", exec_phase, m_exec);
      chk("R8 pc", pc, m_pc);
      chk("R4 instr", instr, m_ir);
      chk(m_exec ? "R5 mem_addr" : "R3 mem_addr", mem_addr, ea);
      chk(m_exec ? "R6 mem_we" : "R9 mem_we", mem_we, m_exec & wr);
      chk("R6 mem_wdata", mem_wdata, wd);
      chk("R7 rd_valid", rd_valid, m_exec);
      chk("R7 rd_data", rd_data, m_exec ? mem[ea] : '0);
      s_we = mem_we; s_addr = mem_addr; s_wd = mem_wdata;
      @(posedge clk);
      if (!m_exec) m_ir = mem[m_pc];
      m_pc   = exp_next_pc(m_exec, jr, jt);
      m_exec = !m_exec;
      if (s_we) mem[s_addr] = s_wd;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk("R1 phase", exec_phase, 1'b0);
      chk("R1 pc", pc, RPC);
      chk("R1 instr", instr, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] keep;
      void'($urandom(32'd20240517));
      for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
      model_reset();
      @(negedge clk);
      do_reset();

      // random instruction stream
      for (int n = 0; n < 600; n++) begin
         step(($urandom % 4) == 0, AW'($urandom), 1'($urandom), AW'($urandom),
              ($urandom % 3) == 0, DW'($urandom));
      end

      // R9: jump and write requested during fetch are ignored
      if (m_exec) step(1'b0, '0, 1'b0, '0, 1'b0, '0);
      keep = mem[m_pc];
      step(1'b1, 8'h33, 1'b1, 8'h44, 1'b1, 16'hDEAD);
      chk("R9 pc after fetch", pc, m_pc);
      chk("R9 memory untouched", mem[pc], keep);

      // R8: jump to top address, then wrap to zero
      step(1'b1, 8'hFF, 1'b1, 8'h01, 1'b0, '0);
      step(1'b0, '0, 1'b0, '0, 1'b0, '0);
      step(1'b0, '0, 1'b1, 8'h02, 1'b1, 16'h1234);
      chk("R8 wrap", pc, 8'h00);
      chk("R6 write landed", mem[8'h02], 16'h1234);

      // R5: address taken from instruction field
      step(1'b0, '0, 1'b0, '0, 1'b0, '0);
      step(1'b0, '0, 1'b0, 8'hAA, 1'b0, '0);

      // R1: reset asserted in the middle of execute
      if (!m_exec) step(1'b0, '0, 1'b0, '0, 1'b0, '0);
      wr_req = 1'b1; jump_req = 1'b1;
      do_reset();
      for (int n = 0; n < 40; n++) begin
         step(1'($urandom), AW'($urandom), 1'($urandom), AW'($urandom),
              1'($urandom), DW'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule